// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Staged Page Writes

This block is the slave side of a two-wire serial memory interface. It runs on the system clock, takes clock and data lines that are already synchronized, and pulls the data line low through a single output. Its storage is a byte-wide array of up to 512 bytes that sits outside the block behind a simple read and write port. The block decodes START and STOP, checks the control byte, keeps an address pointer, and serves byte writes, page writes, current-address reads, random reads and sequential reads.

Write data is not stored in the array while the master is sending it. Data bytes go into a page buffer that wraps. Once STOP arrives, a self-timed write cycle copies the buffered bytes into the array and then waits a set number of cycles. For that whole time the slave refuses every control byte, so a master can poll for completion by watching for the acknowledge. A write-protect input, whose active level is a parameter, can veto the commit.

Top module: `ee_serial_slave`

## Requirements
- R1: START is data falling while clock is high. STOP is data rising while clock is high. The pull-low output changes only after the slave has seen clock low.
- R2: A control byte is acknowledged only when its upper nibble is 1010. Bit 0 of the control byte selects read (1) or write (0). With any other code the slave gives no acknowledge and ignores the bus until the next START.
- R3: With 512 bytes, bit 1 of an acknowledged control byte becomes address bit 8 of the pointer, for reads and for writes. The next byte then sets address bits 7..0. With 128 bytes, bits 3..1 are ignored.
- R4: In a write, the byte after the control byte loads the pointer. A following data byte is stored at that address, but only after STOP.
- R5: In a page write, each data byte moves only the low log2(PAGE_BYTES) pointer bits forward. When more than PAGE_BYTES bytes are sent, the position wraps inside the page and later bytes replace earlier ones.
- R6: A write ended by a repeated START, or by a STOP that arrives part way through a byte, stores nothing.
- R7: After a committing STOP the slave is busy: it stores the buffered bytes and then waits WRITE_CYCLES cycles. During that time it does not acknowledge any control byte. After that it acknowledges again.
- R8: The write-protect level is sampled at STOP. When it is at the protecting level, nothing is stored. Reads are not affected.
- R9: A read without an address returns the byte at the pointer, which is one past the last address accessed.
- R10: A random read loads the pointer with a write header, then uses a repeated START and a read control byte. It returns the byte at the loaded address.
- R11: In a read, a master acknowledge makes the slave send the byte at the next address, wrapping from the top of the array to 0. A master no-acknowledge releases the data line and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (wired level) |
| wp_i | input | 1 | Hardware write-protect level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| mem_addr_o | output | log2(MEM_BYTES) | Array address, for read and write |
| mem_wdata_o | output | 8 | Byte to store |
| mem_we_o | output | 1 | Store strobe, one byte per cycle |
| mem_rdata_i | input | 8 | Array contents at mem_addr_o, same cycle |

## Verification
Write traffic is tried in four shapes: a single byte in the upper block, a page that overruns its length by two bytes, a write cut off by a repeated START, and a write cut off part way through a byte. Together they show whether data is stored only on a clean STOP, and whether overrun bytes land back inside the page rather than in the next one. Protected writes are tried with the protect level held for the whole transfer and with it dropped just before STOP, which shows that the level is sampled at STOP. Reads are tried as current-address, random and sequential across the top of the array. This shows whether the pointer is advanced by accesses and whether it wraps to 0. Polling right after STOP and again after the write time shows when acknowledges stop and when they return.

// File: rtl/ee_slave_pkg.sv
package ee_slave_pkg;

    localparam logic [3:0] CTRL_CODE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_ADDR,
        S_WDATA,
        S_TX
    } link_state_e;

    typedef enum logic [1:0] {
        C_IDLE,
        C_STORE,
        C_WAIT
    } commit_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic code_ok(input logic [7:0] b);
        return b[7:4] == CTRL_CODE;
    endfunction

endpackage

// File: rtl/ee_bus_events.sv
module ee_bus_events
    import ee_slave_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start = scl_q & scl_i & sda_q & ~sda_i;
        ev_o.stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev_o.rise  = ~scl_q & scl_i;
        ev_o.fall  = scl_q & ~scl_i;
    end
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int PAGE_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr_i,
    input  logic                          wr_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] widx_i,
    input  logic [7:0]                    wdata_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] ridx_i,
    output logic [7:0]                    rdata_o,
    output logic                          rvalid_o,
    output logic                          any_o
);
    logic [7:0]            slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) valid_q <= '0;
        else if (wr_i)    valid_q[widx_i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_i) slot_q[widx_i] <= wdata_i;
    end

    assign rdata_o  = slot_q[ridx_i];
    assign rvalid_o = valid_q[ridx_i];
    assign any_o    = |valid_q;
endmodule

// File: rtl/ee_commit.sv
module ee_commit
    import ee_slave_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 200
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          go_i,
    input  logic                          slot_valid_i,
    output logic [$clog2(PAGE_BYTES)-1:0] idx_o,
    output logic                          we_o,
    output logic                          busy_o
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    commit_phase_e phase_q;
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= C_IDLE;
            idx_o   <= '0;
            wait_q  <= '0;
        end else begin
            case (phase_q)
                C_IDLE: if (go_i) begin
                    phase_q <= C_STORE;
                    idx_o   <= '0;
                end
                C_STORE: begin
                    if (idx_o == PW'(PAGE_BYTES - 1)) begin
                        phase_q <= C_WAIT;
                        wait_q  <= '0;
                    end else begin
                        idx_o <= idx_o + 1'b1;
                    end
                end
                C_WAIT: begin
                    if (wait_q == CW'(WRITE_CYCLES - 1)) phase_q <= C_IDLE;
                    else                                 wait_q  <= wait_q + 1'b1;
                end
                default: phase_q <= C_IDLE;
            endcase
        end
    end

    assign we_o   = (phase_q == C_STORE) && slot_valid_i;
    assign busy_o = (phase_q != C_IDLE);
endmodule

// File: rtl/ee_serial_slave.sv
module ee_serial_slave
    import ee_slave_pkg::*;
#(
    parameter int MEM_BYTES    = 512,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 200,
    parameter bit WP_LEVEL     = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         scl_i,
    input  logic                         sda_i,
    input  logic                         wp_i,
    output logic                         sda_pull_o,
    output logic [$clog2(MEM_BYTES)-1:0] mem_addr_o,
    output logic [7:0]                   mem_wdata_o,
    output logic                         mem_we_o,
    input  logic [7:0]                   mem_rdata_i
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    bus_ev_t     ev;
    link_state_e state_q;
    logic [3:0]  cnt_q;
    logic [7:0]  shr_q, tx_q;
    logic [AW-1:0] ptr_q, ptr_ctrl, addr_load;
    logic        mack_q, pull_q;
    logic        wc_busy, buf_clr, buf_wr, buf_any, slot_valid, commit_go;
    logic [PW-1:0] wc_idx;
    logic        byte_done, ack_done;

    ee_bus_events u_ev (.clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev));

    // Variant pick: block bit from the control byte only above 256 bytes
    generate
        if (AW > 8) begin : g_blk
            assign ptr_ctrl  = {shr_q[1], ptr_q[AW-2:0]};
            assign addr_load = {ptr_q[AW-1:8], shr_q};
        end else begin : g_noblk
            assign ptr_ctrl  = ptr_q;
            assign addr_load = shr_q[AW-1:0];
        end
    endgenerate

    assign byte_done = ev.fall && (cnt_q == 4'd8);
    assign ack_done  = ev.fall && (cnt_q == 4'd9);
    assign buf_clr   = byte_done && (state_q == S_ADDR);
    assign buf_wr    = byte_done && (state_q == S_WDATA);
    assign commit_go = ev.stop && (state_q == S_WDATA) && (cnt_q == 4'd1)
                       && buf_any && (wp_i != WP_LEVEL);

    ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst(rst), .clr_i(buf_clr), .wr_i(buf_wr),
        .widx_i(ptr_q[PW-1:0]), .wdata_i(shr_q),
        .ridx_i(wc_idx), .rdata_o(mem_wdata_o), .rvalid_o(slot_valid), .any_o(buf_any)
    );

    ee_commit #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
        .clk(clk), .rst(rst), .go_i(commit_go), .slot_valid_i(slot_valid),
        .idx_o(wc_idx), .we_o(mem_we_o), .busy_o(wc_busy)
    );

    assign mem_addr_o = wc_busy ? {ptr_q[AW-1:PW], wc_idx} : ptr_q;
    assign sda_pull_o = pull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            shr_q   <= '0;
            tx_q    <= 8'hFF;
            ptr_q   <= '0;
            mack_q  <= 1'b1;
            pull_q  <= 1'b0;
        end else if (ev.start) begin
            state_q <= S_CTRL;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else if (ev.stop) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else if (state_q != S_IDLE) begin
            if (ev.rise) begin
                if (cnt_q < 4'd8)  shr_q  <= {shr_q[6:0], sda_i};
                if (cnt_q == 4'd8) mack_q <= sda_i;
                cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
                case (state_q)
                    S_CTRL: begin
                        if (code_ok(shr_q) && !wc_busy) begin
                            pull_q <= 1'b1;
                            ptr_q  <= ptr_ctrl;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end
                    S_ADDR: begin
                        pull_q <= 1'b1;
                        ptr_q  <= addr_load;
                    end
                    S_WDATA: begin
                        pull_q <= 1'b1;
                        ptr_q[PW-1:0] <= ptr_q[PW-1:0] + 1'b1;
                    end
                    default: pull_q <= 1'b0;
                endcase
            end else if (ack_done) begin
                cnt_q <= '0;
                if ((state_q == S_CTRL && shr_q[0]) || (state_q == S_TX && !mack_q)) begin
                    state_q <= S_TX;
                    pull_q  <= ~mem_rdata_i[7];
                    tx_q    <= {mem_rdata_i[6:0], 1'b1};
                    ptr_q   <= ptr_q + 1'b1;
                end else begin
                    pull_q <= 1'b0;
                    case (state_q)
                        S_CTRL:  state_q <= S_ADDR;
                        S_ADDR:  state_q <= S_WDATA;
                        S_WDATA: state_q <= S_WDATA;
                        default: state_q <= S_IDLE;
                    endcase
                end
            end else if (ev.fall && state_q == S_TX && cnt_q != 4'd0) begin
                pull_q <= ~tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b1};
            end
        end
    end
endmodule

// File: rtl/ee_serial_slave_chk.sv
module ee_serial_slave_chk
    import ee_slave_pkg::*;
#(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_i,
    input logic          sda_pull_o,
    input logic          busy_i,
    input link_state_e   state_i,
    input logic          fall_i,
    input logic [3:0]    cnt_i,
    input logic          mack_i,
    input logic [AW-1:0] ptr_i
);
    // R1
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

    // R7
    no_ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && state_i == S_CTRL) |-> !sda_pull_o);

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_i == S_IDLE) |-> !sda_pull_o);

    // R11
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_i == S_TX && fall_i && cnt_i == 4'd9 && !mack_i)
        |=> ptr_i == AW'($past(ptr_i) + 1'b1));
endmodule

bind ee_serial_slave ee_serial_slave_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
    .busy_i(wc_busy), .state_i(state_q), .fall_i(ev.fall), .cnt_i(cnt_q),
    .mack_i(mack_q), .ptr_i(ptr_q)
);

// File: tb/ee_serial_slave_tb.sv
module ee_serial_slave_tb;
    localparam int MEM_BYTES = 512;
    localparam int PAGE      = 16;
    localparam int WCYC      = 200;
    localparam int AW        = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
    logic sda_pull, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic sda_line;
    logic [7:0] mem [MEM_BYTES];
    logic [7:0] exp_mem [MEM_BYTES];
    logic [7:0] payload [32];
    int n_chk = 0, n_bad = 0, we_cnt = 0, r1_viol = 0;
    logic prev_scl = 1'b1, prev_pull = 1'b0;

    always #2 clk = ~clk;

    assign sda_line  = m_sda & ~sda_pull;
    assign mem_rdata = mem[mem_addr];

    ee_serial_slave #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC),
                      .WP_LEVEL(1'b1)) u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .wp_i(wp),
        .sda_pull_o(sda_pull), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= init_val(i);
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    // R1: pull-low must not move while the clock line stays high
    always @(negedge clk) begin
        if (!rst && m_scl && prev_scl && sda_pull != prev_pull) r1_viol++;
        prev_scl  = m_scl;
        prev_pull = sda_pull;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; half(); m_scl = 1'b1; half();
        m_sda = 1'b0; half(); m_scl = 1'b0; half();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; half(); m_scl = 1'b1; half(); m_scl = 1'b0; half();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; half(); m_scl = 1'b1; half();
        ack = (sda_line == 1'b0);
        m_scl = 1'b0; half();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            half(); m_scl = 1'b1; half(); b[i] = sda_line; m_scl = 1'b0;
        end
        half(); m_sda = give_ack ? 1'b0 : 1'b1; half();
        m_scl = 1'b1; half(); m_scl = 1'b0; half(); m_sda = 1'b1;
    endtask

    task automatic wait_commit();
        repeat (PAGE + WCYC + 20) @(negedge clk);
    endtask

    task automatic poll(output logic ack);
        i2c_start(); send_byte(8'hA0, ack); i2c_stop();
    endtask

    task automatic t_reset();
        check(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
        check(mem_we == 1'b0, "R4 reset we", mem_we, 0);
    endtask

    task automatic t_byte_write();
        logic a0, a1, a2, p;
        i2c_start(); send_byte(8'hA2, a0); send_byte(8'h05, a1); send_byte(8'hA5, a2); i2c_stop();
        check(a0 && a1 && a2, "R2 acks on write", {a0, a1, a2}, 3'b111);
        poll(p);
        check(!p, "R7 nack while busy", p, 0);
        wait_commit();
        poll(p);
        check(p, "R7 ack after write time", p, 1);
        exp_mem[9'h105] = 8'hA5;
        check(mem[9'h105] == 8'hA5, "R4 byte stored", mem[9'h105], 8'hA5);
        check(mem[9'h005] == exp_mem[9'h005], "R3 block bit to MSB", mem[9'h005], exp_mem[9'h005]);
    endtask

    task automatic t_current_read();
        logic a; logic [7:0] d;
        i2c_start(); send_byte(8'hA3, a); recv_byte(1'b0, d); i2c_stop();
        check(d == exp_mem[9'h106], "R9 current address read", d, exp_mem[9'h106]);
    endtask

    task automatic t_page_write();
        logic a, p;
        for (int k = 0; k < 18; k++) payload[k] = 8'hC0 + 8'(k);
        i2c_start(); send_byte(8'hA0, a); send_byte(8'h0E, a);
        for (int k = 0; k < 18; k++) send_byte(payload[k], a);
        i2c_stop();
        wait_commit(); poll(p);
        exp_mem[9'h00E] = payload[16];
        exp_mem[9'h00F] = payload[17];
        for (int k = 0; k < 14; k++) exp_mem[k] = payload[2 + k];
        for (int k = 0; k < 17; k++)
            check(mem[k] == exp_mem[k], "R5 page wrap", mem[k], exp_mem[k]);
    endtask

    task automatic t_abort();
        logic a; int w0;
        w0 = we_cnt;
        i2c_start(); send_byte(8'hA0, a); send_byte(8'h20, a); send_byte(8'h11, a);
        i2c_start(); send_byte(8'hA0, a); i2c_stop();
        wait_commit();
        check(we_cnt == w0, "R6 restart aborts", we_cnt, w0);
        check(mem[9'h020] == exp_mem[9'h020], "R6 no store on restart", mem[9'h020], exp_mem[9'h020]);
        i2c_start(); send_byte(8'hA0, a); send_byte(8'h21, a); send_byte(8'h22, a);
        send_bits(8'hF0, 4); i2c_stop();
        wait_commit();
        check(we_cnt == w0, "R6 partial byte aborts", we_cnt, w0);
        check(mem[9'h021] == exp_mem[9'h021], "R6 no store on partial", mem[9'h021], exp_mem[9'h021]);
    endtask

    task automatic t_protect();
        logic a; logic [7:0] d; int w0;
        w0 = we_cnt;
        wp = 1'b1;
        i2c_start(); send_byte(8'hA0, a); send_byte(8'h30, a); send_byte(8'h5A, a); i2c_stop();
        wait_commit();
        check(we_cnt == w0, "R8 protected no store", we_cnt, w0);
        i2c_start(); send_byte(8'hA0, a); send_byte(8'h30, a);
        i2c_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); i2c_stop();
        check(d == exp_mem[9'h030], "R8 R10 read under protect", d, exp_mem[9'h030]);
        i2c_start(); send_byte(8'hA0, a); send_byte(8'h31, a); send_byte(8'h6B, a);
        wp = 1'b0; i2c_stop();
        wait_commit();
        exp_mem[9'h031] = 8'h6B;
        check(mem[9'h031] == 8'h6B, "R8 level sampled at stop", mem[9'h031], 8'h6B);
    endtask

    task automatic t_seq_read();
        logic a; logic [7:0] d;
        i2c_start(); send_byte(8'hA2, a); send_byte(8'hFE, a);
        i2c_start(); send_byte(8'hA3, a);
        recv_byte(1'b1, d); check(d == exp_mem[9'h1FE], "R10 random read", d, exp_mem[9'h1FE]);
        recv_byte(1'b1, d); check(d == exp_mem[9'h1FF], "R11 seq top", d, exp_mem[9'h1FF]);
        recv_byte(1'b1, d); check(d == exp_mem[9'h000], "R11 wrap to 0", d, exp_mem[9'h000]);
        recv_byte(1'b0, d); check(d == exp_mem[9'h001], "R11 seq next", d, exp_mem[9'h001]);
        half();
        check(sda_pull == 1'b0, "R11 release after nack", sda_pull, 0);
        i2c_stop();
        i2c_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); i2c_stop();
        check(d == exp_mem[9'h002], "R9 pointer after seq", d, exp_mem[9'h002]);
    endtask

    task automatic t_bad_code();
        logic a0, a1;
        i2c_start(); send_byte(8'hB0, a0); send_byte(8'h00, a1); i2c_stop();
        check(!a0, "R2 wrong code nack", a0, 0);
        check(!a1, "R2 ignored until start", a1, 0);
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) exp_mem[i] = init_val(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_byte_write();
        t_current_read();
        t_page_write();
        t_abort();
        t_protect();
        t_seq_read();
        t_bad_code();
        check(r1_viol == 0, "R1 pull stable while clock high", r1_viol, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule